// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Enables

This block is a small bank of memory-mapped registers that sits between a register bus and a storage-interface PHY sequencer. It holds seven 16-bit control words and presents one read-only status word. Every bus write carries its own enable mask in the upper half-word: data bit x changes only when bit x+16 of the write data is set. Software can therefore change a single field, such as the DLL enable, without reading the word first. The mask half is never stored.

The stored control bits are decoded into named fields that go straight to the PHY sequencer: the power-up and DLL-enable bits, the drive-strength code, the DLL frequency select, and the output tap delay controls. The status word shows two live PHY inputs, calibration-complete and DLL-locked, at the moment a read is accepted.

The bus is a valid/ready interface that accepts one access every cycle. A small two-state machine sequences read responses. In state IDLE no response is pending. An accepted read takes the transition IDLE→RESP (or RESP→RESP when reads come back to back), and read data is presented in RESP. A write or an idle cycle takes the transition RESP→IDLE (or IDLE→IDLE).

Top module: `phy_ctl_regbank`

## Requirements
- R1: A synchronous active-low reset clears all seven control words, so every decoded output is 0, including power-up and DLL enable; no response is pending after reset.
- R2: On a write to a control word, data bit x (0..15) takes write-data bit x when write-data bit x+16 is 1, and otherwise keeps its old value.
- R3: A read accepted on one clock edge raises rsp_valid with rsp_rdata for exactly the following cycle. rsp_rdata holds the stored 16 bits in bits 15:0 and zeros in bits 31:16. A write never raises rsp_valid.
- R4: Control words live at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18, and a write to one never changes another.
- R5: In the word at 0x18, bit 0 drives pwr_on (1 = powered up), bit 1 drives dll_en, and bits 6:4 drive drive_code (0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm).
- R6: In the word at 0x00, bits 13:12 drive freq_sel (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz), bit 11 drives otap_en, and bits 10:7 drive otap_sel.
- R7: A read of offset 0x20 returns phy_cal_done in bit 6 and phy_dll_ready in bit 5, with all other bits zero. Writes to 0x20 change nothing.
- R8: Any other offset, including an unaligned one, reads as zero and ignores writes.
- R9: req_ready is always 1, and accesses on consecutive cycles are each accepted, including a read right after a write to the same word, which returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset |
| req_wdata | input | 32 | Upper 16 bits are the enable mask, lower 16 bits are the data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| phy_cal_done | input | 1 | Calibration complete from the PHY |
| phy_dll_ready | input | 1 | DLL locked from the PHY |
| pwr_on | output | 1 | PHY power-up control |
| dll_en | output | 1 | DLL enable |
| drive_code | output | 3 | Output drive-strength code |
| freq_sel | output | 2 | DLL frequency select |
| otap_en | output | 1 | Output tap delay enable |
| otap_sel | output | 4 | Output tap delay select |

## Verification
The masked write is tried with three kinds of input. All-ones masks check plain storage. All-zero masks check that old values are kept. Random masks with random data tell a correct per-bit merge apart from a mask that is ignored, inverted or shifted. Random traffic also covers the status offset, unmapped offsets and unaligned offsets. This shows whether writes there leak into a control word, and whether reads of them return stale data instead of zero. Directed cases cover three situations. Back-to-back write-then-read tells apart read data captured after the update from data captured before it. Read-then-read exercises the RESP→RESP transition. The toggled status inputs confirm that the status bits are sampled live rather than stored.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RESP = 1'b1
    } bus_state_e;
endpackage

// File: rtl/phy_ctl_word.sv
module phy_ctl_word #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= (q & ~wr_mask) | (wr_data & wr_mask);
    end
endmodule

// File: rtl/phy_ctl_bus_fsm.sv
module phy_ctl_bus_fsm
    import phy_ctl_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [BUS_W-1:0] rd_value,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_rdata
);
    bus_state_e state_q, state_d;
    logic       rd_accept;

    assign req_ready = 1'b1;
    assign rd_accept = req_valid && req_ready && !req_write;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = rd_accept ? S_RESP : S_IDLE;
            S_RESP:  state_d = rd_accept ? S_RESP : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rsp_rdata <= '0;
        else if (rd_accept)
            rsp_rdata <= rd_value;
    end

    assign rsp_valid = (state_q == S_RESP);
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank #(
    parameter int          BUS_W      = 32,
    parameter int          ADDR_W     = 8,
    parameter int          NUM_CTL    = 7,
    parameter logic [7:0]  STATUS_OFF = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_rdata,
    input  logic              phy_cal_done,
    input  logic              phy_dll_ready,
    output logic              pwr_on,
    output logic              dll_en,
    output logic [2:0]        drive_code,
    output logic [1:0]        freq_sel,
    output logic              otap_en,
    output logic [3:0]        otap_sel
);
    localparam int HALF_W    = BUS_W / 2;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int PWR_WORD  = 6;
    localparam int TAP_WORD  = 0;
    localparam int CAL_BIT   = 6;
    localparam int LOCK_BIT  = 5;

    logic [IDX_W-1:0]  idx;
    logic              is_ctl;
    logic              is_status;
    logic [HALF_W-1:0] ctl_q [NUM_CTL];
    logic [HALF_W-1:0] sel_word;
    logic [BUS_W-1:0]  rd_value;
    logic              wr_go;

    assign idx       = req_addr[ADDR_W-1:2];
    assign is_ctl    = (req_addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_CTL));
    assign is_status = (req_addr == ADDR_W'(STATUS_OFF));
    assign wr_go     = req_valid && req_ready && req_write && is_ctl;

    for (genvar g = 0; g < NUM_CTL; g++) begin : g_word
        phy_ctl_word #(.WIDTH(HALF_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_go && (idx == IDX_W'(g))),
            .wr_data (req_wdata[HALF_W-1:0]),
            .wr_mask (req_wdata[BUS_W-1:HALF_W]),
            .q       (ctl_q[g])
        );
    end

    always_comb begin
        sel_word = '0;
        for (int k = 0; k < NUM_CTL; k++)
            if (idx == IDX_W'(k)) sel_word = ctl_q[k];
    end

    always_comb begin
        rd_value = '0;
        if (is_ctl) begin
            rd_value[HALF_W-1:0] = sel_word;
        end else if (is_status) begin
            rd_value[CAL_BIT]  = phy_cal_done;
            rd_value[LOCK_BIT] = phy_dll_ready;
        end
    end

    phy_ctl_bus_fsm #(.BUS_W(BUS_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .rd_value  (rd_value),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign pwr_on     = ctl_q[PWR_WORD][0];
    assign dll_en     = ctl_q[PWR_WORD][1];
    assign drive_code = ctl_q[PWR_WORD][6:4];
    assign freq_sel   = ctl_q[TAP_WORD][13:12];
    assign otap_en    = ctl_q[TAP_WORD][11];
    assign otap_sel   = ctl_q[TAP_WORD][10:7];
endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
    parameter int ADDR_W = 8,
    parameter int BUS_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [BUS_W-1:0]  req_wdata,
    input logic              rsp_valid,
    input logic [BUS_W-1:0]  rsp_rdata,
    input logic              phy_cal_done,
    input logic              pwr_on
);
    logic unmapped_now;
    assign unmapped_now = !((req_addr[1:0] == 2'b00) && (req_addr <= 8'h18))
                          && (req_addr != 8'h20);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pwr_on && !rsp_valid));

    // R3
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    // R3
    no_wr_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[BUS_W-1:BUS_W/2] == '0));

    // R2
    pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_addr == 8'h18 && req_wdata[16]) |=> $stable(pwr_on));

    // R7
    cal_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 8'h20) |=> (rsp_rdata[6] == $past(phy_cal_done)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && unmapped_now) |=> (rsp_rdata == '0));

    // R9
    ready_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .phy_cal_done (phy_cal_done),
    .pwr_on       (pwr_on)
);

// File: tb/tb_phy_ctl_regbank.sv
module tb_phy_ctl_regbank;
    localparam time CLK_T = 20ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic        req_write = 0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        phy_cal_done = 0;
    logic        phy_dll_ready = 0;
    logic        pwr_on, dll_en, otap_en;
    logic [2:0]  drive_code;
    logic [1:0]  freq_sel;
    logic [3:0]  otap_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] model [7];

    always #(CLK_T/2) clk = ~clk;

    phy_ctl_regbank dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        if (a[1:0] == 2'b00 && a <= 8'h18) return {16'h0, model[a[7:2]]};
        if (a == 8'h20) return {25'h0, phy_cal_done, phy_dll_ready, 5'h0};
        return 32'h0;
    endfunction

    task automatic check_fields(string tag);
        check({tag, " R5 pwr_on"},     {31'h0, pwr_on},     {31'h0, model[6][0]});
        check({tag, " R5 dll_en"},     {31'h0, dll_en},     {31'h0, model[6][1]});
        check({tag, " R5 drive_code"}, {29'h0, drive_code}, {29'h0, model[6][6:4]});
        check({tag, " R6 freq_sel"},   {30'h0, freq_sel},   {30'h0, model[0][13:12]});
        check({tag, " R6 otap_en"},    {31'h0, otap_en},    {31'h0, model[0][11]});
        check({tag, " R6 otap_sel"},   {28'h0, otap_sel},   {28'h0, model[0][10:7]});
    endtask

    // Drive at negedge, accepted at next posedge, return at the following negedge.
    task automatic do_write(logic [7:0] a, logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        check("R9 ready", {31'h0, req_ready}, 32'h1);
        @(posedge clk);
        if (a[1:0] == 2'b00 && a <= 8'h18)
            model[a[7:2]] = (model[a[7:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
        @(negedge clk);
        req_valid = 0;
        check("R3 no response after write", {31'h0, rsp_valid}, 32'h0);
        check_fields("after write");
    endtask

    task automatic do_read(logic [7:0] a, string req);
        logic [31:0] e;
        req_valid = 1; req_write = 0; req_addr = a;
        e = exp_read(a);
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        check("R3 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        check(req, rsp_rdata, e);
    endtask

    function automatic string req_of(logic [7:0] a);
        if (a == 8'h20) return "R7 status read";
        if (a[1:0] == 2'b00 && a <= 8'h18) return "R4 control read";
        return "R8 unmapped read";
    endfunction

    function automatic logic [7:0] rand_addr();
        int s = $urandom_range(0, 9);
        if (s < 7) return 8'(s * 4);
        if (s == 7) return 8'h20;
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        #(CLK_T * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 7; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        check_fields("R1 reset");
        for (int i = 0; i < 7; i++) do_read(8'(i * 4), "R1 word zero after reset");

        // R2 full mask, zero mask, partial mask
        do_write(8'h18, 32'hFFFF_0073);
        do_read(8'h18, "R2 full mask write");
        do_write(8'h18, 32'h0000_FFFF);
        do_read(8'h18, "R2 zero mask keeps value");
        do_write(8'h18, 32'h0002_0000);
        check("R2 dll_en cleared alone", {31'h0, dll_en}, 32'h0);
        check("R2 pwr_on kept", {31'h0, pwr_on}, 32'h1);
        // R5 drive code 4 (40 ohm)
        do_write(8'h18, 32'h0070_0040);
        check("R5 drive 40 ohm code", {29'h0, drive_code}, 32'h4);
        // R6 freq 150 MHz, tap enabled, tap select 0xA
        do_write(8'h00, 32'h3F80_3D00);
        check("R6 freq_sel 150 MHz", {30'h0, freq_sel}, 32'h3);
        check("R6 otap_sel", {28'h0, otap_sel}, 32'hA);
        // R4 independence
        do_write(8'h0C, 32'hFFFF_BEEF);
        do_read(8'h08, "R4 neighbour untouched");
        do_read(8'h10, "R4 neighbour untouched");
        // R7 status, write ignored, live sampling
        do_write(8'h20, 32'hFFFF_FFFF);
        phy_cal_done = 1; phy_dll_ready = 0;
        do_read(8'h20, "R7 status cal only");
        phy_cal_done = 0; phy_dll_ready = 1;
        do_read(8'h20, "R7 status lock only");
        // R8 unmapped and unaligned
        do_write(8'h1C, 32'hFFFF_FFFF);
        do_write(8'h01, 32'hFFFF_FFFF);
        do_read(8'h1C, "R8 unmapped read zero");
        do_read(8'h01, "R8 unaligned read zero");
        for (int i = 0; i < 7; i++) do_read(8'(i * 4), "R8 unmapped write ignored");
        // R9 write then read same word back to back; read then read
        do_write(8'h14, 32'h00FF_00A5);
        do_read(8'h14, "R9 read after write sees new value");
        do_read(8'h0C, "R9 consecutive read");
        do_read(8'h00, "R9 consecutive read");

        // Random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = rand_addr();
            phy_cal_done  = 1'($urandom_range(0, 1));
            phy_dll_ready = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) do_write(a, $urandom());
            else do_read(a, req_of(a));
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check("R3 rsp_valid idle", {31'h0, rsp_valid}, 32'h0);
            end
        end

        // R1 reset again clears everything
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 7; i++) model[i] = '0;
        @(negedge clk);
        check_fields("R1 second reset");
        do_read(8'h18, "R1 word zero after reset");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule